// File: doc/BRIEF.md
# Packet Buffer Data Pointer and Address Generator

This block holds the 16-bit pointer that software programs before it moves bytes in or out of a paged packet buffer. It also turns each byte access through a four-byte data window into an address on a synchronous RAM. The top bit of the pointer picks which page is used: either the head of the receive queue or the current packet number. The next bit picks between two addressing styles. In the first, a sequential stream advances the pointer by one byte on every access. In the second, a fixed base is combined with the low two bits of the window address, and the pointer is left alone.

Register accesses are single-cycle byte strobes on a 4-bit address. The pointer's low byte sits at address 6 and its high byte at address 7. The data window covers addresses 8 to 11. Every read returns its byte on `bus_rdata` in the cycle after the strobe. For data reads that byte comes straight from the RAM read port.

Top module: `pkt_ptr_agen`

## Requirements
- R1: After reset the pointer is zero, so reads of addresses 6 and 7 both return 0x00.
- R2: A byte write to address 6 loads pointer bits [7:0], and a byte write to address 7 loads bits [15:8]. A read of address 6 returns bits [7:0]. A read of address 7 returns bits [15:8] ANDed with 0xF7, so bit 11 always reads as zero. No other access changes the pointer, except the increment in R5.
- R3: The RAM address is {page, byte offset}. The page is `rxq_head` when pointer bit 15 is 1, and `pkt_num` when it is 0.
- R4: When pointer bit 14 is 0, a data-window access uses byte offset (pointer[10:0] + bus_addr[1:0]) modulo 2048, and the pointer does not change.
- R5: When pointer bit 14 is 1, a data-window access uses byte offset pointer[10:0]. After that access, pointer[10:0] becomes (old value + 1) modulo 2048 and bits [15:11] keep their value.
- R6: Only reads or writes at addresses 8 to 11 assert `ram_en`. A read of any address other than 6 to 11 returns 0x00.
- R7: A window write drives `ram_we` with `bus_wdata` in the strobe cycle. A window read returns the RAM byte at the generated address on `bus_rdata` one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 4 | Byte register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| pkt_num | input | 2 | Current packet number (page when bit 15 is 0) |
| rxq_head | input | 2 | Receive queue head (page when bit 15 is 1) |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 13 | RAM byte address {page, offset} |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after ram_en |

## Verification
A missed or doubled increment of the offset shows up at the next window access. The `ram_addr` value in that strobe cycle is off by one, and a pointer readback at address 6 shows the same error one cycle after its strobe. A wrong page choice or a failed wrap at the 2047 boundary shows on `ram_addr` during that same access, and the wrong byte returns on `bus_rdata` one cycle later. Corrupted upper pointer bits, including a stored bit 11 leaking into the readback, are seen at the next read of address 7.

// File: rtl/pkt_ptr_agen.sv
module pkt_ptr_agen #(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 2048,
  localparam int PG_W  = $clog2(PAGES),
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int AW    = PG_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [3:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [PG_W-1:0] pkt_num,
  input  logic [PG_W-1:0] rxq_head,
  output logic            ram_en,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [7:0]      ram_wdata,
  input  logic [7:0]      ram_rdata
);

  logic [15:0] ptr;
  logic        rd_ram_q;
  logic [7:0]  rd_reg_q;

  wire in_win = (bus_addr[3:2] == 2'b10);
  wire acc    = (bus_wr | bus_rd) & in_win;
  wire autoinc = ptr[14];
  wire [OFF_W-1:0] base = ptr[OFF_W-1:0];
  wire [OFF_W-1:0] off  = autoinc ? base : base + OFF_W'(bus_addr[1:0]);
  wire [PG_W-1:0]  page = ptr[15] ? rxq_head : pkt_num;

  assign ram_en    = acc;
  assign ram_we    = acc & bus_wr;
  assign ram_addr  = {page, off};
  assign ram_wdata = bus_wdata;
  assign bus_rdata = rd_ram_q ? ram_rdata : rd_reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (bus_wr && bus_addr == 4'd6) begin
      ptr[7:0] <= bus_wdata;
    end else if (bus_wr && bus_addr == 4'd7) begin
      ptr[15:8] <= bus_wdata;
    end else if (acc && autoinc) begin
      ptr[OFF_W-1:0] <= base + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ram_q <= 1'b0;
      rd_reg_q <= '0;
    end else begin
      rd_ram_q <= bus_rd & in_win & ~bus_wr;
      if (bus_rd && bus_addr == 4'd6)      rd_reg_q <= ptr[7:0];
      else if (bus_rd && bus_addr == 4'd7) rd_reg_q <= ptr[15:8] & 8'hF7;
      else                                 rd_reg_q <= '0;
    end
  end

endmodule

// File: rtl/ptr_agen_chk.sv
module ptr_agen_chk #(
  parameter int PG_W  = 2,
  parameter int OFF_W = 11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [3:0]            bus_addr,
  input logic [PG_W-1:0]       pkt_num,
  input logic [PG_W-1:0]       rxq_head,
  input logic                  ram_en,
  input logic [PG_W+OFF_W-1:0] ram_addr,
  input logic [15:0]           ptr
);

  wire ptr_wr = bus_wr && (bus_addr == 4'd6 || bus_addr == 4'd7);

  // R5
  autoinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ptr[14]) |=> ptr[OFF_W-1:0] == OFF_W'($past(ptr[OFF_W-1:0]) + 1'b1));

  // R5
  autoinc_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ptr[14]) |=> $stable(ptr[15:11]));

  // R4
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ptr[14]) |=> $stable(ptr));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !ram_en) |=> $stable(ptr));

  // R6
  ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (bus_addr[3:2] == 2'b10 && (bus_rd || bus_wr)));

  // R3
  page_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> ram_addr[PG_W+OFF_W-1:OFF_W] == (ptr[15] ? rxq_head : pkt_num));

endmodule

bind pkt_ptr_agen ptr_agen_chk #(.PG_W(PG_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .pkt_num(pkt_num), .rxq_head(rxq_head),
  .ram_en(ram_en), .ram_addr(ram_addr), .ptr(ptr)
);

// File: tb/sim_pkt_ptr_agen.sv
`timescale 1ns/1ps
module sim_pkt_ptr_agen;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, ram_wdata, ram_rdata = 0;
  logic [1:0] pkt_num = 0, rxq_head = 0;
  logic ram_en, ram_we;
  logic [12:0] ram_addr;

  int checks = 0, fails = 0;
  logic [15:0] mptr;
  logic [7:0] mmem [logic [12:0]];
  logic [7:0] bmem [logic [12:0]];

  always #10 clk = ~clk;

  pkt_ptr_agen u0 (.*);

  function automatic logic [7:0] fill(logic [12:0] a);
    return 8'(a ^ (a >> 5) ^ 13'h5A);
  endfunction

  always @(posedge clk) if (ram_en) begin
    ram_rdata <= bmem.exists(ram_addr) ? bmem[ram_addr] : fill(ram_addr);
    if (ram_we) bmem[ram_addr] = ram_wdata;
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    #2;
    if (a < 8 || a > 11) chk("R6", ram_en, 0);
    @(negedge clk); bus_wr = 0;
    if (a == 6) mptr[7:0] = d;
    if (a == 7) mptr[15:8] = d;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #2;
    if (a < 8 || a > 11) chk("R6", ram_en, 0);
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic chk_ptr(string r);
    logic [7:0] v;
    rd(6, v); chk(r, v, mptr[7:0]);
    rd(7, v); chk(r, v, mptr[15:8] & 8'hF7);
  endtask

  task automatic data(bit w, logic [1:0] idx, logic [7:0] d);
    logic [12:0] ea;
    logic [10:0] off;
    logic [7:0] e;
    string r;
    r = mptr[14] ? "R5" : "R4";
    off = mptr[14] ? mptr[10:0] : 11'(mptr[10:0] + idx);
    ea = {mptr[15] ? rxq_head : pkt_num, off};
    @(negedge clk); bus_wr = w; bus_rd = !w; bus_addr = {2'b10, idx}; bus_wdata = d;
    #2;
    chk("R6", ram_en, 1);
    chk("R3", ram_addr[12:11], ea[12:11]);
    chk(r, ram_addr[10:0], off);
    if (w) begin chk("R7", ram_we, 1); chk("R7", ram_wdata, d); end
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    if (w) mmem[ea] = d;
    else begin
      e = mmem.exists(ea) ? mmem[ea] : fill(ea);
      chk("R7", bus_rdata, e);
    end
    if (mptr[14]) mptr[10:0] = mptr[10:0] + 11'd1;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    mptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6, v); chk("R1", v, 0);
    rd(7, v); chk("R1", v, 0);
    // R2 masking of bit 11
    wr(6, 8'hFF); wr(7, 8'hFF);
    rd(7, v); chk("R2", v, 8'hF7);
    rd(6, v); chk("R2", v, 8'hFF);
    // R6 other addresses read zero and leave the pointer alone
    wr(0, 8'h12); wr(12, 8'h34);
    rd(3, v); chk("R6", v, 0);
    chk_ptr("R2");
    // R5 wrap with upper bits kept, bit 11 set
    pkt_num = 2; rxq_head = 1;
    wr(7, 8'h4F); wr(6, 8'hFF);
    data(1, 2, 8'hA5);
    chk_ptr("R5");
    data(0, 1, 0);
    chk_ptr("R5");
    // R4 window wrap, no pointer change
    wr(7, 8'h07); wr(6, 8'hFE);
    data(1, 3, 8'h3C);
    data(0, 3, 0);
    chk_ptr("R4");
    // R3 page from receive head
    wr(7, 8'h80); wr(6, 8'h10);
    data(1, 0, 8'h77);
    rxq_head = 3;
    data(0, 0, 0);
    pkt_num = 3; rxq_head = 1;
    wr(7, 8'h00);
    data(0, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op == 0) begin
        wr(6, 8'($urandom)); wr(7, 8'($urandom));
      end else if (op == 1) begin
        pkt_num = 2'($urandom); rxq_head = 2'($urandom);
      end else if (op == 2) begin
        chk_ptr(mptr[14] ? "R5" : "R4");
      end else if (op == 3) begin
        wr(4'($urandom_range(0, 5)), 8'($urandom));
      end else begin
        data(bit'($urandom), 2'($urandom), 8'($urandom));
      end
    end
    chk_ptr("R2");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule